// File: doc/BRIEF.md
# Preemptive Earliest-Deadline Task Scheduler

This block decides which task occupies one compute node. A task arrives through a release event that carries a task number and a deadline. The task that is running keeps the node unless a newly released task has a strictly earlier deadline. In that case the running task is pushed out with a preempt command, and the newcomer is started in the same cycle. Tasks that cannot run wait in a small list. Each entry of that list remembers whether the task was preempted.

When the running task reports that it has finished, the scheduler dispatches the waiting entry with the earliest deadline. It sends a start command if that task has never run, and a resume command if it was preempted. A task that migrates to another node can be withdrawn from the waiting list. The node also reports continuously how many of its execution contexts are still unoccupied.

The controller has two named states. IDLE means no task holds the node, and the waiting list is then always empty. BUSY means a task holds the node. The named transitions are:
- IDLE→BUSY on a release (dispatch-new).
- BUSY→BUSY on an earlier-deadline release (preempt-swap).
- BUSY→BUSY on a later or equal release (enqueue).
- BUSY→BUSY on a matching finish with a non-empty list (dispatch-next).
- BUSY→IDLE on a matching finish with an empty list (drain).
- BUSY→BUSY on a removal (withdraw).

Top module: `edf_scheduler`

## Requirements
- R1: A release seen in IDLE produces `cmd_run` high with `cmd_id` equal to the released number for exactly one cycle, in the cycle after the sampling edge. The state then becomes BUSY.
- R2: In BUSY, a release whose deadline is strictly smaller than the running task's deadline raises `cmd_preempt` with `preempt_id` set to the old task, together with `cmd_run` and `cmd_id` set to the new task, in the same cycle. The old task joins the waiting list marked as preempted.
- R3: In BUSY, a release whose deadline is equal to or larger than the running deadline produces no command. The task joins the waiting list marked as new.
- R4: A finish whose number matches the running task dispatches the waiting entry with the smallest deadline, with the smallest task number winning a tie. The dispatch is `cmd_resume` if the entry is marked preempted and `cmd_run` otherwise. With an empty list, the state returns to IDLE and no command is issued. A finish with a non-matching number, or one seen in IDLE, has no effect.
- R5: A removal deletes every waiting entry holding that number. A number that is not waiting leaves the list unchanged, and a removal never issues a command.
- R6: `free_ctx` equals NUM_CTX minus the occupied count, saturated at 0. The occupied count is one for a running task plus the number of waiting entries. The value reflects the state after each edge.
- R7: The waiting list holds DEPTH (8) entries. A release that needs a slot while the list is full is dropped with no command, including a release that would otherwise preempt. Such a release sets `overflow`, which stays high until reset.
- R8: At most one event is acted on per cycle, with priority finish, then release, then removal. Lower-priority events in the same cycle are discarded.
- R9: After reset the state is IDLE, the list is empty, all command strobes and `overflow` are low, and `free_ctx` equals NUM_CTX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rel_valid | input | 1 | Release event |
| rel_id | input | ID_W | Released task number |
| rel_deadline | input | DL_W | Released task deadline (smaller is more urgent) |
| fin_valid | input | 1 | Finish event |
| fin_id | input | ID_W | Number of the finishing task |
| rm_valid | input | 1 | Migration removal event |
| rm_id | input | ID_W | Number of the task to withdraw |
| cmd_run | output | 1 | Start strobe for a never-run task |
| cmd_resume | output | 1 | Resume strobe for a preempted task |
| cmd_id | output | ID_W | Task number for start or resume |
| cmd_preempt | output | 1 | Preempt strobe |
| preempt_id | output | ID_W | Task number being preempted |
| free_ctx | output | FREE_W | Count of unoccupied contexts |
| overflow | output | 1 | Sticky waiting-list overflow flag |

## Verification
A wrong stored deadline, task number or preempted mark stays invisible until that entry is dispatched. It then appears as the wrong number or as a start instead of a resume, in the cycle after the finish that drains to it. For that reason, every scenario drains the list to the end. A lost or duplicated entry shifts `free_ctx` right away, as long as occupancy stays below NUM_CTX. Beyond that point it shows only as a missing or extra dispatch at the end of the drain. A wrong running deadline shows up one cycle after the next release, as a preempt that should not happen or a missing one.

// File: rtl/edf_sched_pkg.sv
package edf_sched_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } sched_state_e;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_FINISH  = 2'd1,
        EV_RELEASE = 2'd2,
        EV_REMOVE  = 2'd3
    } sched_event_e;
endpackage

// File: rtl/edf_event_pick.sv
module edf_event_pick
    import edf_sched_pkg::*;
(
    input  logic         fin_valid,
    input  logic         rel_valid,
    input  logic         rm_valid,
    output sched_event_e ev
);
    // finish outranks release, release outranks removal (R8)
    always_comb begin
        if (fin_valid)      ev = EV_FINISH;
        else if (rel_valid) ev = EV_RELEASE;
        else if (rm_valid)  ev = EV_REMOVE;
        else                ev = EV_NONE;
    end
endmodule

// File: rtl/edf_min_select.sv
module edf_min_select #(
    parameter int ID_W  = 4,
    parameter int DL_W  = 8,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             vld [DEPTH],
    input  logic [ID_W-1:0]  ids [DEPTH],
    input  logic [DL_W-1:0]  dls [DEPTH],
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [DL_W-1:0] best_dl;
    logic [ID_W-1:0] best_id;

    // earliest deadline wins, lowest task number breaks a tie
    always_comb begin
        any     = 1'b0;
        idx     = '0;
        best_dl = '0;
        best_id = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (!any || dls[i] < best_dl ||
                           (dls[i] == best_dl && ids[i] < best_id))) begin
                any     = 1'b1;
                idx     = IDX_W'(i);
                best_dl = dls[i];
                best_id = ids[i];
            end
        end
    end
endmodule

// File: rtl/edf_wait_list.sv
module edf_wait_list #(
    parameter int ID_W  = 4,
    parameter int DL_W  = 8,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [ID_W-1:0]  ins_id,
    input  logic [DL_W-1:0]  ins_dl,
    input  logic             ins_pre,
    input  logic             rm_en,
    input  logic [ID_W-1:0]  rm_id,
    input  logic             pop_en,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic [ID_W-1:0]  sel_id,
    output logic [DL_W-1:0]  sel_dl,
    output logic             sel_pre
);
    logic             vld  [DEPTH];
    logic [ID_W-1:0]  ids  [DEPTH];
    logic [DL_W-1:0]  dls  [DEPTH];
    logic             pres [DEPTH];
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_any;

    edf_min_select #(.ID_W(ID_W), .DL_W(DL_W), .DEPTH(DEPTH)) u_min (
        .vld (vld),
        .ids (ids),
        .dls (dls),
        .any (sel_any),
        .idx (sel_idx)
    );

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(vld[i]);
    end

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = !sel_any;
    assign sel_id  = ids[sel_idx];
    assign sel_dl  = dls[sel_idx];
    assign sel_pre = pres[sel_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld[i]  <= 1'b0;
                ids[i]  <= '0;
                dls[i]  <= '0;
                pres[i] <= 1'b0;
            end
        end else begin
            if (ins_en) begin
                vld[free_idx]  <= 1'b1;
                ids[free_idx]  <= ins_id;
                dls[free_idx]  <= ins_dl;
                pres[free_idx] <= ins_pre;
            end
            if (rm_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (vld[i] && ids[i] == rm_id) vld[i] <= 1'b0;
                end
            end
            if (pop_en) vld[sel_idx] <= 1'b0;
        end
    end

    // R7: the controller never writes into a full list
    assert_no_insert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !full);
    // R7: occupancy never exceeds the capacity
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R4: a dispatch only happens from a non-empty list
    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty);
endmodule

// File: rtl/edf_scheduler.sv
module edf_scheduler
    import edf_sched_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int DL_W    = 8,
    parameter int DEPTH   = 8,
    parameter int NUM_CTX = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int FREE_W = $clog2(NUM_CTX + 1),
    localparam int OCC_W  = $clog2(DEPTH + NUM_CTX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_valid,
    input  logic [ID_W-1:0]   rel_id,
    input  logic [DL_W-1:0]   rel_deadline,
    input  logic              fin_valid,
    input  logic [ID_W-1:0]   fin_id,
    input  logic              rm_valid,
    input  logic [ID_W-1:0]   rm_id,
    output logic              cmd_run,
    output logic              cmd_resume,
    output logic [ID_W-1:0]   cmd_id,
    output logic              cmd_preempt,
    output logic [ID_W-1:0]   preempt_id,
    output logic [FREE_W-1:0] free_ctx,
    output logic              overflow
);
    localparam logic [OCC_W-1:0] CTX_L = OCC_W'(NUM_CTX);

    sched_state_e     state, state_nxt;
    sched_event_e     ev;
    logic [ID_W-1:0]  run_id, run_id_nxt;
    logic [DL_W-1:0]  run_dl, run_dl_nxt;
    logic             run_nxt, res_nxt, pre_nxt, ovf_nxt;
    logic [ID_W-1:0]  cmd_id_nxt, pre_id_nxt;

    logic             ins_en, ins_pre, rm_en, pop_en;
    logic [ID_W-1:0]  ins_id;
    logic [DL_W-1:0]  ins_dl;
    logic             wl_full, wl_empty, sel_pre;
    logic [CNT_W-1:0] wl_count;
    logic [ID_W-1:0]  sel_id;
    logic [DL_W-1:0]  sel_dl;
    logic [OCC_W-1:0] occ;

    edf_event_pick u_pick (
        .fin_valid (fin_valid),
        .rel_valid (rel_valid),
        .rm_valid  (rm_valid),
        .ev        (ev)
    );

    edf_wait_list #(.ID_W(ID_W), .DL_W(DL_W), .DEPTH(DEPTH)) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_en  (ins_en),
        .ins_id  (ins_id),
        .ins_dl  (ins_dl),
        .ins_pre (ins_pre),
        .rm_en   (rm_en),
        .rm_id   (rm_id),
        .pop_en  (pop_en),
        .full    (wl_full),
        .empty   (wl_empty),
        .count   (wl_count),
        .sel_id  (sel_id),
        .sel_dl  (sel_dl),
        .sel_pre (sel_pre)
    );

    // next-state and command decision
    always_comb begin
        state_nxt  = state;
        run_id_nxt = run_id;
        run_dl_nxt = run_dl;
        run_nxt    = 1'b0;
        res_nxt    = 1'b0;
        pre_nxt    = 1'b0;
        cmd_id_nxt = cmd_id;
        pre_id_nxt = preempt_id;
        ovf_nxt    = overflow;
        ins_en     = 1'b0;
        ins_id     = rel_id;
        ins_dl     = rel_deadline;
        ins_pre    = 1'b0;
        rm_en      = 1'b0;
        pop_en     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (ev == EV_RELEASE) begin           // dispatch-new
                    state_nxt  = S_BUSY;
                    run_nxt    = 1'b1;
                    cmd_id_nxt = rel_id;
                    run_id_nxt = rel_id;
                    run_dl_nxt = rel_deadline;
                end else if (ev == EV_REMOVE) begin
                    rm_en = 1'b1;
                end
            end
            S_BUSY: begin
                unique case (ev)
                    EV_FINISH: begin
                        if (fin_id == run_id) begin
                            if (wl_empty) begin       // drain
                                state_nxt = S_IDLE;
                            end else begin            // dispatch-next
                                pop_en     = 1'b1;
                                run_nxt    = !sel_pre;
                                res_nxt    = sel_pre;
                                cmd_id_nxt = sel_id;
                                run_id_nxt = sel_id;
                                run_dl_nxt = sel_dl;
                            end
                        end
                    end
                    EV_RELEASE: begin
                        if (wl_full) begin
                            ovf_nxt = 1'b1;
                        end else if (rel_deadline < run_dl) begin  // preempt-swap
                            ins_en     = 1'b1;
                            ins_id     = run_id;
                            ins_dl     = run_dl;
                            ins_pre    = 1'b1;
                            pre_nxt    = 1'b1;
                            pre_id_nxt = run_id;
                            run_nxt    = 1'b1;
                            cmd_id_nxt = rel_id;
                            run_id_nxt = rel_id;
                            run_dl_nxt = rel_deadline;
                        end else begin                // enqueue
                            ins_en = 1'b1;
                        end
                    end
                    EV_REMOVE: rm_en = 1'b1;          // withdraw
                    default: ;
                endcase
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            run_id <= '0;
            run_dl <= '0;
        end else begin
            state  <= state_nxt;
            run_id <= run_id_nxt;
            run_dl <= run_dl_nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_run     <= 1'b0;
            cmd_resume  <= 1'b0;
            cmd_preempt <= 1'b0;
            cmd_id      <= '0;
            preempt_id  <= '0;
            overflow    <= 1'b0;
        end else begin
            cmd_run     <= run_nxt;
            cmd_resume  <= res_nxt;
            cmd_preempt <= pre_nxt;
            cmd_id      <= cmd_id_nxt;
            preempt_id  <= pre_id_nxt;
            overflow    <= ovf_nxt;
        end
    end

    assign occ      = OCC_W'(wl_count) + OCC_W'(state == S_BUSY);
    assign free_ctx = (occ >= CTX_L) ? '0 : FREE_W'(CTX_L - occ);

    // R2: a preempt is always paired with a start of the newcomer
    assert_preempt_with_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_preempt |-> cmd_run);
    // R4: start and resume are never issued together
    assert_run_resume_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_run, cmd_resume}));
    // R4: an idle node never has waiting tasks
    assert_idle_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> wl_empty);
    // R7: overflow is sticky until reset
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R6: free count never exceeds the node's contexts
    assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_ctx <= FREE_W'(NUM_CTX));
endmodule

// File: tb/test_edf_scheduler.sv
`timescale 1ns/1ps
module test_edf_scheduler;
    localparam int ID_W = 4;
    localparam int DL_W = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            rel_valid, fin_valid, rm_valid;
    logic [ID_W-1:0] rel_id, fin_id, rm_id;
    logic [DL_W-1:0] rel_deadline;
    logic            cmd_run, cmd_resume, cmd_preempt, overflow;
    logic [ID_W-1:0] cmd_id, preempt_id;
    logic [1:0]      free_ctx;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    edf_scheduler #(.ID_W(ID_W), .DL_W(DL_W), .DEPTH(8), .NUM_CTX(2)) i_edf_scheduler (
        .clk(clk), .rst_n(rst_n),
        .rel_valid(rel_valid), .rel_id(rel_id), .rel_deadline(rel_deadline),
        .fin_valid(fin_valid), .fin_id(fin_id),
        .rm_valid(rm_valid), .rm_id(rm_id),
        .cmd_run(cmd_run), .cmd_resume(cmd_resume), .cmd_id(cmd_id),
        .cmd_preempt(cmd_preempt), .preempt_id(preempt_id),
        .free_ctx(free_ctx), .overflow(overflow)
    );

    // kind: 0 none, 1 release, 2 finish, 3 remove
    typedef struct packed {
        logic [1:0] kind;
        logic [3:0] id;
        logic [7:0] dl;
        logic       e_run;
        logic       e_res;
        logic       e_pre;
        logic [3:0] e_id;
        logic [3:0] e_pid;
        logic [1:0] e_free;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 4'd1, 8'd50, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0, 2'd1},
        '{2'd1, 4'd2, 8'd60, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 2'd0},
        '{2'd1, 4'd3, 8'd50, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 2'd0},
        '{2'd1, 4'd4, 8'd20, 1'b1, 1'b0, 1'b1, 4'd4, 4'd1, 2'd0},
        '{2'd2, 4'd4, 8'd0,  1'b0, 1'b1, 1'b0, 4'd1, 4'd0, 2'd0},
        '{2'd3, 4'd3, 8'd0,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 2'd0},
        '{2'd2, 4'd9, 8'd0,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 2'd0},
        '{2'd2, 4'd1, 8'd0,  1'b1, 1'b0, 1'b0, 4'd2, 4'd0, 2'd1},
        '{2'd2, 4'd2, 8'd0,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 2'd2},
        '{2'd1, 4'd5, 8'd10, 1'b1, 1'b0, 1'b0, 4'd5, 4'd0, 2'd1},
        '{2'd1, 4'd6, 8'd5,  1'b1, 1'b0, 1'b1, 4'd6, 4'd5, 2'd0},
        '{2'd2, 4'd6, 8'd0,  1'b0, 1'b1, 1'b0, 4'd5, 4'd0, 2'd1},
        '{2'd2, 4'd5, 8'd0,  1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 2'd2}
    };
    localparam string TAGS [NV] = '{"R1", "R3", "R3", "R2", "R4", "R5", "R4",
                                    "R4", "R4", "R1", "R2", "R4", "R4"};

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one cycle with any mix of events; outputs are sampled afterwards at the falling edge
    task automatic drive(input logic rv, input int rid, input int rdl,
                         input logic fv, input int fid, input logic mv, input int mid);
        rel_valid    = rv;
        rel_id       = ID_W'(rid);
        rel_deadline = DL_W'(rdl);
        fin_valid    = fv;
        fin_id       = ID_W'(fid);
        rm_valid     = mv;
        rm_id        = ID_W'(mid);
        @(negedge clk);
        rel_valid = 1'b0;
        fin_valid = 1'b0;
        rm_valid  = 1'b0;
    endtask

    task automatic rel(input int id, input int dl);
        drive(1'b1, id, dl, 1'b0, 0, 1'b0, 0);
    endtask

    task automatic fin(input int id);
        drive(1'b0, 0, 0, 1'b1, id, 1'b0, 0);
    endtask

    task automatic expect_cmd(input string req, input logic r, input logic s, input logic p, input int id);
        check(req, "cmd_run", int'(cmd_run), int'(r));
        check(req, "cmd_resume", int'(cmd_resume), int'(s));
        check(req, "cmd_preempt", int'(cmd_preempt), int'(p));
        if (r || s) check(req, "cmd_id", int'(cmd_id), id);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rel_valid = 1'b0; fin_valid = 1'b0; rm_valid = 1'b0;
        rel_id = '0; fin_id = '0; rm_id = '0; rel_deadline = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "cmd_run", int'(cmd_run), 0);
        check("R9", "cmd_preempt", int'(cmd_preempt), 0);
        check("R9", "overflow", int'(overflow), 0);
        check("R9", "free_ctx", int'(free_ctx), 2);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].kind == 2'd1, int'(VEC[k].id), int'(VEC[k].dl),
                  VEC[k].kind == 2'd2, int'(VEC[k].id),
                  VEC[k].kind == 2'd3, int'(VEC[k].id));
            check(TAGS[k], "cmd_run", int'(cmd_run), int'(VEC[k].e_run));
            check(TAGS[k], "cmd_resume", int'(cmd_resume), int'(VEC[k].e_res));
            check(TAGS[k], "cmd_preempt", int'(cmd_preempt), int'(VEC[k].e_pre));
            if (VEC[k].e_run || VEC[k].e_res)
                check(TAGS[k], "cmd_id", int'(cmd_id), int'(VEC[k].e_id));
            if (VEC[k].e_pre)
                check(TAGS[k], "preempt_id", int'(preempt_id), int'(VEC[k].e_pid));
            check("R6", "free_ctx", int'(free_ctx), int'(VEC[k].e_free));
        end

        // R7: fill the list, overflow on the ninth waiting entry
        rel(0, 100);
        expect_cmd("R1", 1'b1, 1'b0, 1'b0, 0);
        for (int i = 1; i <= 8; i++) begin
            rel(i, 200);
            expect_cmd("R3", 1'b0, 1'b0, 1'b0, 0);
        end
        check("R7", "overflow before full insert", int'(overflow), 0);
        rel(9, 200);
        check("R7", "overflow", int'(overflow), 1);
        expect_cmd("R7", 1'b0, 1'b0, 1'b0, 0);
        rel(10, 1);
        expect_cmd("R7", 1'b0, 1'b0, 1'b0, 0);
        check("R7", "overflow sticky", int'(overflow), 1);
        // drain: dropped tasks 9 and 10 never appear
        fin(0);
        expect_cmd("R4", 1'b1, 1'b0, 1'b0, 1);
        for (int i = 1; i < 8; i++) begin
            fin(i);
            expect_cmd("R7", 1'b1, 1'b0, 1'b0, i + 1);
        end
        fin(8);
        expect_cmd("R7", 1'b0, 1'b0, 1'b0, 0);
        check("R6", "free_ctx after drain", int'(free_ctx), 2);

        // R8: finish outranks release in the same cycle
        drive(1'b1, 3, 9, 1'b1, 3, 1'b0, 0);
        expect_cmd("R8", 1'b0, 1'b0, 1'b0, 0);
        check("R8", "free_ctx", int'(free_ctx), 2);
        // R8: release outranks removal
        drive(1'b1, 2, 9, 1'b0, 0, 1'b1, 2);
        expect_cmd("R8", 1'b1, 1'b0, 1'b0, 2);
        rel(7, 50);
        drive(1'b1, 6, 50, 1'b0, 0, 1'b1, 7);
        expect_cmd("R8", 1'b0, 1'b0, 1'b0, 0);
        // R5: absent number leaves the list alone
        drive(1'b0, 0, 0, 1'b0, 0, 1'b1, 12);
        expect_cmd("R5", 1'b0, 1'b0, 1'b0, 0);
        fin(2);
        expect_cmd("R4", 1'b1, 1'b0, 1'b0, 6);
        fin(6);
        expect_cmd("R8", 1'b1, 1'b0, 1'b0, 7);
        fin(7);
        expect_cmd("R4", 1'b0, 1'b0, 1'b0, 0);
        check("R6", "free_ctx idle", int'(free_ctx), 2);

        // R9: reset clears the sticky flag and a running task
        rel(4, 30);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "overflow after reset", int'(overflow), 0);
        check("R9", "free_ctx after reset", int'(free_ctx), 2);
        rst_n = 1'b1;
        @(negedge clk);
        fin(4);
        expect_cmd("R9", 1'b0, 1'b0, 1'b0, 0);
        rel(5, 30);
        expect_cmd("R1", 1'b1, 1'b0, 1'b0, 5);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule